// File: doc/BRIEF.md
# Re-patchable Arithmetic and Logic Slice

This block is one 32-bit slice of a hardware accelerator whose operators can be altered after the chip is made. Each fixed operator is replaced by a small configurable unit. The add/subtract unit adds or subtracts a writable constant. The comparator tests a signed relation against a second writable constant. The logic unit combines the two data operands bitwise. When a later revision of the accelerated code changes one of these operations, a new operation select or a new constant is shifted in. The hardware is not redesigned.

All selects and both constants are held in one serial configuration chain. It loads one bit per clock while the scan enable is high, and its serial output returns the old contents for readback. Some patches cannot be expressed by the units: a reserved encoding, or an explicit request to fall back. For these the slice raises a trap in place of a result, and the host processor then runs the computation in software. The slice has one registered stage.

Top module: `patch_slice`

## Requirements
- R1: After reset all configuration bits and both constants are zero, which selects add, relation EQ, bitwise AND and trap-enable clear. At the same time `out_valid`, `trap`, `scan_out`, `res_sum`, `res_cmp` and `res_logic` are all zero.
- R2: While `scan_en` is high the configuration chain shifts one position per clock. `scan_in` enters at the low end and `scan_out` shows the bit at the high end of the chain. The chain is 71 bits long. Counting from the `scan_out` end, it holds the subtract bit, then the 3-bit relation field, the 2-bit bitwise field, the trap-enable bit, the 32-bit add constant K0 and the 32-bit compare constant K1. Each field is loaded most significant bit first. Shifting 71 further bits moves the loaded contents out of `scan_out` in the same order in which they were loaded.
- R3: While `scan_en` is low the configuration is held unchanged, whatever the data inputs do.
- R4: One clock after an accepted operation, `res_sum` equals `opnd_a + K0` when the subtract bit is 0. It equals `opnd_a - K0` when the bit is 1, taken modulo 2^32. An operation is accepted when `in_valid` is high and `scan_en` is low. The same cycle raises `out_valid`.
- R5: One clock after an accepted operation, `res_cmp` gives the signed comparison of `opnd_a` with K1. The relation field selects it: 0 EQ, 1 NE, 2 LT, 3 LE, 4 GT, 5 GE.
- R6: One clock after an accepted operation, `res_logic` equals `opnd_a` combined with `opnd_b`. The bitwise field selects the operation: 0 AND, 1 OR, 2 XOR.
- R7: A cycle with `scan_en` high never produces a result. In the next cycle `out_valid` and `trap` are both low and the results keep their values.
- R8: An accepted operation raises `trap` for one clock in place of a result when any of these holds: the relation field is 6 or 7, the bitwise field is 3, or trap-enable is 1. In that clock `out_valid` is low and the results keep their values. `trap` and `out_valid` are never high together.
- R9: A cycle with `in_valid` low leaves `out_valid` and `trap` low in the next cycle and the results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Shift the configuration chain this cycle |
| scan_in | input | 1 | Serial configuration data in |
| scan_out | output | 1 | Serial configuration data out (high end of chain) |
| in_valid | input | 1 | Operands present this cycle |
| opnd_a | input | 32 | First data operand |
| opnd_b | input | 32 | Second data operand (logic unit) |
| out_valid | output | 1 | Results below belong to the previous accepted operation |
| trap | output | 1 | Previous accepted operation must run in software |
| res_sum | output | 32 | Add/subtract result |
| res_cmp | output | 1 | Comparison result |
| res_logic | output | 32 | Bitwise result |

## Verification
Every result, `out_valid` and `trap` is due exactly one clock after the cycle that presented the operands. The same holds for the shifted `scan_out` after a scan cycle, because each of these passes through a single register. The reference model in the bench advances on the same rising edge the design uses, from the inputs and the configuration it held before that edge. Both sides are compared at the following falling edge, so each expectation is sampled in the cycle it is due and never earlier or later. Configuration is decoded from a bit queue of the bits shifted in, so the field positions come from the requirement and not from the design.

// File: rtl/patch_slice_pkg.sv
package patch_slice_pkg;

    typedef enum logic [2:0] {
        REL_EQ   = 3'd0,
        REL_NE   = 3'd1,
        REL_LT   = 3'd2,
        REL_LE   = 3'd3,
        REL_GT   = 3'd4,
        REL_GE   = 3'd5,
        REL_RSV6 = 3'd6,
        REL_RSV7 = 3'd7
    } rel_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2,
        BW_RSV = 2'd3
    } bw_e;

    // Selects as they sit at the top of the chain: sub is the highest bit.
    typedef struct packed {
        logic sub;
        rel_e rel;
        bw_e  bw;
        logic trap_en;
    } sel_t;

    localparam int SEL_W = $bits(sel_t);

endpackage

// File: rtl/patch_cfg_chain.sv
module patch_cfg_chain
    import patch_slice_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic              scan_in,
    output logic              scan_out,
    output sel_t              sel,
    output logic [DATA_W-1:0] k_add,
    output logic [DATA_W-1:0] k_cmp
);
    localparam int CHAIN_W = SEL_W + 2 * DATA_W;

    typedef struct packed {
        logic [CHAIN_W-1:0] bits;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (scan_en) begin
            chain_d.bits = {chain_q.bits[CHAIN_W-2:0], scan_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign scan_out = chain_q.bits[CHAIN_W-1];
    assign sel      = sel_t'(chain_q.bits[CHAIN_W-1 -: SEL_W]);
    assign k_add    = chain_q.bits[2*DATA_W-1 -: DATA_W];
    assign k_cmp    = chain_q.bits[DATA_W-1:0];

    // R3: configuration frozen outside scan
    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> $stable(chain_q.bits));

    // R2: one bit enters per scan clock
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (chain_q.bits[0] == $past(scan_in)));

    // R2: the old second-highest bit reaches scan_out
    assert_shift_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (scan_out == $past(chain_q.bits[CHAIN_W-2])));

endmodule

// File: rtl/patch_addsub.sv
module patch_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] k,
    input  logic              sub,
    output logic [DATA_W-1:0] y
);
    logic [DATA_W-1:0] k_inv;
    logic [DATA_W-1:0] cin;

    // one carry chain: subtract is add of the inverted constant plus one
    assign k_inv = k ^ {DATA_W{sub}};
    assign cin   = {{(DATA_W-1){1'b0}}, sub};
    assign y     = a + k_inv + cin;

endmodule

// File: rtl/patch_compare.sv
module patch_compare
    import patch_slice_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  rel_e              rel,
    output logic              hit,
    output logic              bad
);
    logic eq;
    logic lt;

    assign eq = (a == b);
    assign lt = ($signed(a) < $signed(b));

    always_comb begin
        hit = 1'b0;
        bad = 1'b0;
        unique case (rel)
            REL_EQ: hit = eq;
            REL_NE: hit = !eq;
            REL_LT: hit = lt;
            REL_LE: hit = lt || eq;
            REL_GT: hit = !(lt || eq);
            REL_GE: hit = !lt;
            default: bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/patch_logic.sv
module patch_logic
    import patch_slice_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  bw_e               op,
    output logic [DATA_W-1:0] y,
    output logic              bad
);
    assign bad = (op == BW_RSV);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign y[i] = (op == BW_AND) ? (a[i] & b[i]) :
                      (op == BW_OR)  ? (a[i] | b[i]) :
                      (op == BW_XOR) ? (a[i] ^ b[i]) : 1'b0;
    end

endmodule

// File: rtl/patch_slice.sv
module patch_slice
    import patch_slice_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic              scan_in,
    output logic              scan_out,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              out_valid,
    output logic              trap,
    output logic [DATA_W-1:0] res_sum,
    output logic              res_cmp,
    output logic [DATA_W-1:0] res_logic
);
    typedef struct packed {
        logic              vld;
        logic              trap;
        logic [DATA_W-1:0] sum;
        logic              hit;
        logic [DATA_W-1:0] lg;
    } stage_t;

    sel_t              sel;
    logic [DATA_W-1:0] k_add;
    logic [DATA_W-1:0] k_cmp;
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] lg_w;
    logic              hit_w;
    logic              cmp_bad;
    logic              lg_bad;
    logic              fire;
    logic              no_fit;

    stage_t st_d, st_q;

    patch_cfg_chain #(.DATA_W(DATA_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .scan_out (scan_out),
        .sel      (sel),
        .k_add    (k_add),
        .k_cmp    (k_cmp)
    );

    patch_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a   (opnd_a),
        .k   (k_add),
        .sub (sel.sub),
        .y   (sum_w)
    );

    patch_compare #(.DATA_W(DATA_W)) u_cmp (
        .a   (opnd_a),
        .b   (k_cmp),
        .rel (sel.rel),
        .hit (hit_w),
        .bad (cmp_bad)
    );

    patch_logic #(.DATA_W(DATA_W)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .op  (sel.bw),
        .y   (lg_w),
        .bad (lg_bad)
    );

    assign fire   = in_valid && !scan_en;
    assign no_fit = cmp_bad || lg_bad || sel.trap_en;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = fire && !no_fit;
        st_d.trap = fire && no_fit;
        if (fire && !no_fit) begin
            st_d.sum = sum_w;
            st_d.hit = hit_w;
            st_d.lg  = lg_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign trap      = st_q.trap;
    assign res_sum   = st_q.sum;
    assign res_cmp   = st_q.hit;
    assign res_logic = st_q.lg;

    // R7: a scan cycle yields neither result nor trap
    assert_scan_mutes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (!out_valid && !trap));

    // R8: trap and valid exclusive
    assert_trap_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && trap));

    // R8: unsupported patch traps on the next accepted operation
    assert_trap_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !scan_en && (sel.rel > REL_GE || sel.bw == BW_RSV || sel.trap_en))
        |=> (trap && !out_valid));

    // R9: results hold when nothing is accepted
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || scan_en) |=> ($stable(res_sum) && $stable(res_cmp) && $stable(res_logic)));

    // R4: a result always comes from an operand cycle
    assert_valid_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

endmodule

// File: tb/patch_slice_tb.sv
`timescale 1ns/1ps
module patch_slice_tb_top;
    localparam int W = 32;
    localparam int CH = 7 + 2 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scan_en = 1'b0;
    logic         scan_in = 1'b0;
    logic         scan_out;
    logic         in_valid = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         out_valid;
    logic         trap;
    logic [W-1:0] res_sum;
    logic         res_cmp;
    logic [W-1:0] res_logic;

    always #10 clk = ~clk;

    patch_slice #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
        .scan_out(scan_out), .in_valid(in_valid), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .out_valid(out_valid), .trap(trap),
        .res_sum(res_sum), .res_cmp(res_cmp), .res_logic(res_logic)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    bit           q[$];
    logic         e_vld, e_trap, e_cmp;
    logic [W-1:0] e_sum, e_log;
    string        vld_tag;

    function automatic logic [W-1:0] fld(int lo, int n);
        logic [W-1:0] v = '0;
        for (int i = 0; i < n; i++) v = {v[W-2:0], q[lo + i]};
        return v;
    endfunction

    task automatic model_reset();
        q.delete();
        for (int i = 0; i < CH; i++) q.push_back(1'b0);
        e_vld = 0; e_trap = 0; e_cmp = 0; e_sum = '0; e_log = '0;
        vld_tag = "R1";
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            logic         sub, te, fire, bad, h;
            int           rel, bw;
            logic [W-1:0] k0, k1;
            sub = q[0];
            rel = int'(fld(1, 3));
            bw  = int'(fld(4, 2));
            te  = q[6];
            k0  = fld(7, W);
            k1  = fld(7 + W, W);
            fire = in_valid && !scan_en;
            bad  = (rel > 5) || (bw == 3) || te;
            e_vld  = fire && !bad;
            e_trap = fire && bad;
            if (scan_en)      vld_tag = "R7";
            else if (!in_valid) vld_tag = "R9";
            else if (bad)     vld_tag = "R8";
            else              vld_tag = "R4";
            if (e_vld) begin
                e_sum = sub ? (opnd_a - k0) : (opnd_a + k0);
                case (rel)
                    0: h = (opnd_a == k1);
                    1: h = (opnd_a != k1);
                    2: h = ($signed(opnd_a) <  $signed(k1));
                    3: h = ($signed(opnd_a) <= $signed(k1));
                    4: h = ($signed(opnd_a) >  $signed(k1));
                    default: h = ($signed(opnd_a) >= $signed(k1));
                endcase
                e_cmp = h;
                e_log = (bw == 0) ? (opnd_a & opnd_b) :
                        (bw == 1) ? (opnd_a | opnd_b) : (opnd_a ^ opnd_b);
            end
            if (scan_en) begin
                void'(q.pop_front());
                q.push_back(scan_in);
            end
        end
    end

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    logic prev_scan = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(prev_scan ? "R2 scan_out" : "R3 scan_out", W'(scan_out), W'(q[0]));
            chk({vld_tag, " out_valid"}, W'(out_valid), W'(e_vld));
            chk({vld_tag, " trap"}, W'(trap), W'(e_trap));
            chk("R4 res_sum", res_sum, e_sum);
            chk("R5 res_cmp", W'(res_cmp), W'(e_cmp));
            chk("R6 res_logic", res_logic, e_log);
        end
        prev_scan = scan_en;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic op(logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        in_valid = 1'b1; opnd_a = a; opnd_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic op_burst(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; opnd_a = $urandom; opnd_b = $urandom;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic load(logic sub, logic [2:0] rel, logic [1:0] bw, logic te,
                        logic [W-1:0] k0, logic [W-1:0] k1, bit busy);
        logic [CH-1:0] v;
        v = {sub, rel, bw, te, k0, k1};
        for (int i = CH - 1; i >= 0; i--) begin
            @(negedge clk);
            scan_en = 1'b1; scan_in = v[i];
            in_valid = busy; opnd_a = $urandom; opnd_b = $urandom;
        end
        @(negedge clk);
        scan_en = 1'b0; scan_in = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000 - 10) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all-requirements act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: explicit reset-state checks
        chk("R1 scan_out", W'(scan_out), '0);
        chk("R1 out_valid", W'(out_valid), '0);
        chk("R1 trap", W'(trap), '0);
        chk("R1 res_sum", res_sum, '0);
        chk("R1 res_logic", res_logic, '0);
        // R1 default config: add K0=0, EQ against 0, AND
        op(32'h0000_0000, 32'hFFFF_0000);
        op(32'h1234_5678, 32'h0F0F_0F0F);
        op_burst(4);
        // R4/R5/R6 subtract, LT, OR with operands around K1
        load(1'b1, 3'd2, 2'd1, 1'b0, 32'h0000_0005, 32'hFFFF_FFF0, 1'b0);
        op(32'h0000_0003, 32'hA5A5_0000);   // 3-5 wraps
        op(32'hFFFF_FFEF, 32'h0);           // signed -17 < -16
        op(32'hFFFF_FFF0, 32'h1);           // equal
        op(32'h7FFF_FFFF, 32'h2);
        // R5/R6 every legal relation and bitwise code
        for (int r = 0; r < 6; r++) begin
            for (int b = 0; b < 3; b++) begin
                load(r[0], 3'(r), 2'(b), 1'b0, $urandom, 32'h0000_0100, r == 1);
                op(32'h0000_00FF, $urandom);
                op(32'h0000_0100, $urandom);
                op(32'h0000_0101, $urandom);
                op(32'h8000_0000, $urandom);
            end
        end
        // R3: long idle and operand traffic with scan_en low
        op_burst(20);
        // R8: reserved relations, reserved bitwise, trap-enable
        load(1'b0, 3'd6, 2'd0, 1'b0, 32'd1, 32'd2, 1'b0);
        op(32'd7, 32'd9);
        load(1'b0, 3'd7, 2'd2, 1'b0, 32'd1, 32'd2, 1'b0);
        op(32'd7, 32'd9);
        load(1'b1, 3'd0, 2'd3, 1'b0, 32'd1, 32'd2, 1'b0);
        op_burst(3);
        load(1'b0, 3'd4, 2'd2, 1'b1, 32'd1, 32'd2, 1'b0);
        op(32'd7, 32'd9);
        // R7: operands presented during a scan are not accepted
        load(1'b0, 3'd5, 2'd2, 1'b0, 32'hDEAD_BEEF, 32'h0000_0040, 1'b1);
        op(32'h0000_0040, 32'h0000_FFFF);
        // R2: readback, shift the loaded contents out
        load(1'b0, 3'd0, 2'd0, 1'b0, 32'h0, 32'h0, 1'b0);
        op(32'd5, 32'd6);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule